// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles, one quotient bit per cycle, using the restoring method. A pulse on `start` while the block is idle captures both operands and the signed/unsigned select. The block then runs a fixed 33-step sequence. In each step it subtracts a right-shifting copy of the divisor from a running remainder. If the difference is negative, the old remainder is restored and a 0 enters the quotient. Otherwise the difference is kept and a 1 enters the quotient.

In signed mode the block divides the magnitudes and corrects the signs at the end. The quotient is negated when the operand signs differ. The remainder takes the sign of the dividend. The remainder appears on `hi` and the quotient on `lo`, in the same cycle that `done` pulses. Both hold their values until the next division completes.

Nothing in hardware checks for a zero divisor or for signed overflow. Such inputs still run the full sequence and give a fixed, defined result.

Top module: `seq_restoring_div`

## Requirements
- R1: While reset is asserted and after it is released, with no start, `busy` and `done` are 0 and `hi` and `lo` are 0.
- R2: A `start` sampled high on a clock edge while `busy` is 0 is accepted, and `busy` is 1 after that edge. This includes the cycle in which `done` is high.
- R3: After an accepted start, `busy` stays high for exactly 33 cycles. On the edge that ends them, `busy` falls and `done` rises for a single cycle. `busy` and `done` are never high together.
- R4: With `is_signed` = 0 and a nonzero divisor, `lo` equals the unsigned quotient and `hi` the unsigned remainder, which is smaller than the divisor.
- R5: With `is_signed` = 1 (two's complement operands), `lo` is the magnitude quotient, negated when the operand signs differ. `hi` is the magnitude remainder, negated when the dividend is negative.
- R6: A zero divisor completes normally. The magnitude quotient is all ones and the magnitude remainder is the dividend's magnitude. The R5 sign rule is then applied when `is_signed` = 1.
- R7: `start` while `busy` is 1 is ignored. The running division keeps its timing and delivers the result of the first operands.
- R8: `hi` and `lo` change only on the edge where `done` rises, and they keep their values at all other times.
- R9: Signed 0x80000000 divided by 0xFFFFFFFF gives `lo` = 0x80000000 and `hi` = 0, with no special handling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division when idle |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | 32 | Dividend, sampled with an accepted start |
| divisor | input | 32 | Divisor, sampled with an accepted start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| hi | output | 32 | Remainder of the last completed division |
| lo | output | 32 | Quotient of the last completed division |

## Verification
Unsigned operands are tried with these cases:
- Small values that give a nonzero remainder.
- A dividend smaller than the divisor, which must give a zero quotient.
- Full-scale values, which show whether the top quotient bit is kept.

The same bit pattern run both unsigned and signed shows whether the mode select reaches the magnitude and fix-up paths. The three sign combinations of a signed division separate the quotient negation from the remainder negation. A zero divisor and the most-negative dividend over minus one check the two results that need no special handling. A start while busy and a start in the done cycle show whether acceptance depends only on the idle state.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} rdiv_state_e;

  typedef struct packed {
    logic neg_quo;
    logic neg_rem;
  } rdiv_sign_t;
endpackage

// File: rtl/rdiv_sign_prep.sv
module rdiv_sign_prep
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         is_signed_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] num_mag_o,
  output logic [W-1:0] den_mag_o,
  output rdiv_sign_t   sign_o
);
  logic num_neg, den_neg;

  always_comb begin
    num_neg        = is_signed_i & num_i[W-1];
    den_neg        = is_signed_i & den_i[W-1];
    num_mag_o      = num_neg ? (~num_i + W'(1)) : num_i;
    den_mag_o      = den_neg ? (~den_i + W'(1)) : den_i;
    sign_o.neg_quo = num_neg ^ den_neg;
    sign_o.neg_rem = num_neg;
  end
endmodule

// File: rtl/rdiv_step_core.sv
module rdiv_step_core
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] num_mag_i,
  input  logic [W-1:0] den_mag_i,
  output logic         accept_o,
  output logic         last_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_nxt_o,
  output logic [W-1:0] rem_nxt_o
);
  localparam int STEPS = W + 1;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  rdiv_state_e      state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [2*W-1:0]   dvr_q, dvr_d;
  logic [2*W-1:0]   rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic             done_q, done_d;

  logic [2*W:0]     diff;
  logic             went_neg;
  logic [2*W-1:0]   rem_step;
  logic [W-1:0]     quo_step;
  logic             running;

  always_comb begin
    running  = (state_q == ST_RUN);
    diff     = {1'b0, rem_q} - {1'b0, dvr_q};
    went_neg = diff[2*W];
    rem_step = went_neg ? rem_q : diff[2*W-1:0];
    quo_step = {quo_q[W-2:0], ~went_neg};
    accept_o = (state_q == ST_IDLE) & start_i;
    last_o   = running & (cnt_q == LAST);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dvr_d   = dvr_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    done_d  = last_o;
    if (accept_o) begin
      state_d = ST_RUN;
      cnt_d   = '0;
      dvr_d   = {den_mag_i, {W{1'b0}}};
      rem_d   = {{W{1'b0}}, num_mag_i};
      quo_d   = '0;
    end else if (running) begin
      cnt_d = cnt_q + CW'(1);
      dvr_d = {1'b0, dvr_q[2*W-1:1]};
      rem_d = rem_step;
      quo_d = quo_step;
      if (last_o) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dvr_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dvr_q   <= dvr_d;
      rem_q   <= rem_d;
      quo_q   <= quo_d;
      done_q  <= done_d;
    end
  end

  assign busy_o    = running;
  assign done_o    = done_q;
  assign quo_nxt_o = quo_step;
  assign rem_nxt_o = rem_step[W-1:0];

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);
  a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q <= LAST));
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o) |=> (busy_o && cnt_q == $past(cnt_q) + CW'(1)));
  a_r4_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && dvr_q != '0) |-> (rem_step < dvr_q));
  a_r4_quo_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && dvr_q != '0) |-> !quo_q[W-1]);
endmodule

// File: rtl/rdiv_sign_fix.sv
module rdiv_sign_fix
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture_i,
  input  rdiv_sign_t   sign_i,
  input  logic         load_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] rem_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  rdiv_sign_t   sign_q, sign_d;
  logic [W-1:0] hi_d, lo_d;

  always_comb begin
    sign_d = capture_i ? sign_i : sign_q;
    hi_d   = hi_o;
    lo_d   = lo_o;
    if (load_i) begin
      lo_d = sign_q.neg_quo ? (~quo_i + W'(1)) : quo_i;
      hi_d = sign_q.neg_rem ? (~rem_i + W'(1)) : rem_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= '0;
      hi_o   <= '0;
      lo_o   <= '0;
    end else begin
      sign_q <= sign_d;
      hi_o   <= hi_d;
      lo_o   <= lo_d;
    end
  end

  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(hi_o) && $stable(lo_o)));
  a_r5_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && sign_q.neg_rem && rem_i != '0) |=> hi_o[W-1]);
  a_r5_pos_rem: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !sign_q.neg_rem) |=> (hi_o == $past(rem_i)));
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div
  import rdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic [W-1:0] num_mag, den_mag, quo_nxt, rem_nxt;
  rdiv_sign_t   sign_in;
  logic         accept, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rdiv_sign_prep #(.W(W)) u_prep (
    .is_signed_i (is_signed),
    .num_i       (dividend),
    .den_i       (divisor),
    .num_mag_o   (num_mag),
    .den_mag_o   (den_mag),
    .sign_o      (sign_in)
  );

  rdiv_step_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start),
    .num_mag_i (num_mag),
    .den_mag_i (den_mag),
    .accept_o  (accept),
    .last_o    (last),
    .busy_o    (busy),
    .done_o    (done),
    .quo_nxt_o (quo_nxt),
    .rem_nxt_o (rem_nxt)
  );

  rdiv_sign_fix #(.W(W)) u_fix (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .capture_i (accept),
    .sign_i    (sign_in),
    .load_i    (last),
    .quo_i     (quo_nxt),
    .rem_i     (rem_nxt),
    .hi_o      (hi),
    .lo_o      (lo)
  );

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_int_n |-> (!busy && !done && hi == '0 && lo == '0));
endmodule

// File: tb/tb_seq_restoring_div.sv
module tb_seq_restoring_div;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] hi, lo;

  int n_chk = 0;
  int n_bad = 0;

  seq_restoring_div #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  always #5 clk = ~clk;

  function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic sg, output logic [W-1:0] rhi,
                                  output logic [W-1:0] rlo);
    logic [W-1:0] ma, mb, uq, ur;
    logic na, nb;
    na = sg && a[W-1];
    nb = sg && b[W-1];
    ma = na ? -a : a;
    mb = nb ? -b : b;
    if (mb == 0) begin
      uq = '1;
      ur = ma;
    end else begin
      uq = ma / mb;
      ur = ma % mb;
    end
    rlo = (na ^ nb) ? -uq : uq;
    rhi = na ? -ur : ur;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  logic         m_busy = 1'b0, m_done = 1'b0;
  int           m_cnt = 0;
  logic [W-1:0] m_hi = '0, m_lo = '0, p_hi, p_lo;
  logic         cmp_on = 1'b0;

  always @(posedge clk) begin
    m_done <= 1'b0;
    if (!m_busy && start) begin
      ref_div(dividend, divisor, is_signed, p_hi, p_lo);
      m_busy <= 1'b1;
      m_cnt  <= 0;
    end else if (m_busy) begin
      if (m_cnt == W) begin
        m_busy <= 1'b0;
        m_done <= 1'b1;
        m_hi   <= p_hi;
        m_lo   <= p_lo;
      end
      m_cnt <= m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 busy", {31'b0, busy}, {31'b0, m_busy});
      chk("R3 done", {31'b0, done}, {31'b0, m_done});
      chk("R8 hi", hi, m_hi);
      chk("R8 lo", lo, m_lo);
    end
  end

  task automatic wait_done;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic sg, input string tag);
    logic [W-1:0] eh, el;
    ref_div(a, b, sg, eh, el);
    @(negedge clk);
    dividend = a; divisor = b; is_signed = sg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy after start"}, {31'b0, busy}, 32'd1);
    wait_done();
    chk({tag, " lo"}, lo, el);
    chk({tag, " hi"}, hi, eh);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [W-1:0] eh, el;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 hi", hi, 32'd0);
    chk("R1 lo", lo, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {30'b0, busy, done}, 32'd0);
    cmp_on = 1'b1;

    // R4 unsigned
    run(32'd100, 32'd7, 1'b0, "R4 100/7");
    run(32'd5, 32'd10, 1'b0, "R4 small/large");
    run(32'hFFFFFFFF, 32'd1, 1'b0, "R4 full/1");
    run(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R4 full/full");
    run(32'hFFFFFFF9, 32'd2, 1'b0, "R4 pattern unsigned");
    // R5 signed
    run(32'hFFFFFFF9, 32'd2, 1'b1, "R5 -7/2");
    run(32'd7, 32'hFFFFFFFE, 1'b1, "R5 7/-2");
    run(32'hFFFFFFF9, 32'hFFFFFFFE, 1'b1, "R5 -7/-2");
    run(32'd1000, 32'd33, 1'b1, "R5 pos/pos");
    // R6 zero divisor
    run(32'd1234, 32'd0, 1'b0, "R6 unsigned zero div");
    run(32'hFFFFFFFB, 32'd0, 1'b1, "R6 signed zero div");
    // R9 most negative over minus one
    run(32'h80000000, 32'hFFFFFFFF, 1'b1, "R9 min/-1");

    // R7: start while busy is ignored
    @(negedge clk);
    dividend = 32'd90; divisor = 32'd9; is_signed = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    dividend = 32'd77; divisor = 32'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R7 lo kept first", lo, 32'd10);
    chk("R7 hi kept first", hi, 32'd0);
    @(negedge clk);
    chk("R7 no second run", {31'b0, busy}, 32'd0);

    // R2: start in the done cycle is accepted
    @(negedge clk);
    dividend = 32'd50; divisor = 32'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    dividend = 32'd61; divisor = 32'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 back-to-back busy", {31'b0, busy}, 32'd1);
    chk("R2 first result lo", lo, 32'd8);
    wait_done();
    ref_div(32'd61, 32'd8, 1'b0, eh, el);
    chk("R2 second lo", lo, el);
    chk("R2 second hi", hi, eh);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule